// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges every reason a chip may need to restart into one internal active-high reset. The five sources are a supply-level monitor (power-on), an optional undervoltage monitor (brown-out), an external active-low pin, a watchdog strobe and a software strobe. The analog comparators are modelled as digital level inputs that read 1 while the supply is above their threshold. All timing is counted in clock ticks. A microsecond figure becomes `(us * CLK_PER_US) >> TIME_SHIFT` ticks, with a floor of one tick.

On a cold start the block first runs a fixed initialization interval of 92 µs. It then runs a start-up delay picked by a 2-bit fuse code and a crystal/non-crystal flag, and only then releases reset. When undervoltage detection is enabled, the start-up delay also waits for the undervoltage comparator to read good. A low pin at the end of start-up keeps reset asserted whatever the pin fuse says. In normal operation the pin only resets the chip when its fuse is set. A power-off flag records cold starts until software clears it.

Top module: `rstgen_core`

## Requirements
- R1: The watchdog strobe, software strobe, filtered pin, power-on and brown-out paths all drive the single output `rst_out`, which is a register updated on the rising clock edge.
- R2: At every clock edge that samples `por_ok` low, `rst_out` and `pof_out` are 1 after that edge.
- R3: With undervoltage detection off, `rst_out` falls at the edge that comes INIT+SUT edges after the first edge sampling `por_ok` high. INIT is the scaled value of 92 µs.
- R4: SUT depends on `{xtal_sel, sut_code}`. With `xtal_sel`=0, codes 0,1,2,3 give 16, 512, 1024 and 4096 µs. With `xtal_sel`=1, codes 0,1,2,3 give 1024, 2048, 4096 and 16384 µs. All values are scaled.
- R5: With `bod_en`=1, the start-up count begins at the first edge that samples `bod_ok` high, and never before the initialization interval has ended.
- R6: With `bod_en`=1 while running, a low `bod_ok` keeps reset high from the first edge that samples it. Reset falls SUT edges after the first edge sampling it high again. The initialization interval does not rerun and `pof_out` is untouched. With `bod_en`=0, `bod_ok` has no effect.
- R7: The pin is sampled every clock. While running with `pin_rst_en`=1, a low level held for n≥2 consecutive samples gives a reset pulse of exactly n cycles. A single low sample gives none.
- R8: While running with `pin_rst_en`=0, the pin has no effect on `rst_out`.
- R9: During power-up, if the pin reads low for two samples when the start-up delay ends, reset stays high regardless of `pin_rst_en`. Reset falls at the second edge that samples the pin high.
- R10: A watchdog or software request held for k cycles gives a reset pulse of k+1 cycles. This means a one-cycle strobe resets for 2 cycles.
- R11: `pof_out` is cleared by `pof_clr` at an edge where `por_ok` is high. No source other than a low `por_ok` sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_ok | input | 1 | Supply above power-on threshold |
| bod_ok | input | 1 | Supply above undervoltage threshold |
| bod_en | input | 1 | Fuse: enable undervoltage detection |
| pin_rst_en | input | 1 | Fuse: pin acts as reset while running |
| rst_pin_n | input | 1 | Raw external reset pin, active low |
| wdt_req | input | 1 | Watchdog reset request |
| sw_req | input | 1 | Software reset request |
| xtal_sel | input | 1 | Clock source is a crystal |
| sut_code | input | 2 | Start-up time fuse code |
| pof_clr | input | 1 | Clear power-off flag |
| rst_out | output | 1 | Internal reset, active high |
| pof_out | output | 1 | Power-off (cold start) flag |

## Verification
The bench builds the block with CLK_PER_US=1 and TIME_SHIFT=2. This makes the initialization interval 23 ticks and the start-up delays 4 to 4096 ticks. All eight fuse/clock-source delays can therefore be measured exactly, each in its own power cycle, within a short run. The short 4-tick start-up code keeps the brown-out, gated power-up and pin-hold scenarios brief enough for exact pulse lengths to be predicted. Every reset pulse the design emits is matched against a predicted length.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

  typedef enum logic [2:0] {
    PS_OFF     = 3'd0,
    PS_INIT    = 3'd1,
    PS_BODWAIT = 3'd2,
    PS_SUT     = 3'd3,
    PS_HOLD    = 3'd4,
    PS_RUN     = 3'd5
  } pwr_state_e;

  localparam int unsigned INIT_US_DEF = 92;

  // start-up delay in microseconds for a clock source and fuse code
  function automatic int unsigned sut_us(input logic xtal, input logic [1:0] code);
    int unsigned us;
    if (xtal) begin
      case (code)
        2'd0:    us = 1024;
        2'd1:    us = 2048;
        2'd2:    us = 4096;
        default: us = 16384;
      endcase
    end else begin
      case (code)
        2'd0:    us = 16;
        2'd1:    us = 512;
        2'd2:    us = 1024;
        default: us = 4096;
      endcase
    end
    return us;
  endfunction

  // convert microseconds to clock ticks, never less than one tick
  function automatic int unsigned us_to_ticks(input int unsigned us,
                                              input int unsigned clk_per_us,
                                              input int unsigned shift);
    int unsigned t;
    t = (us * clk_per_us) >> shift;
    return (t == 0) ? 1 : t;
  endfunction

endpackage

// File: rtl/rstgen_pin_filter.sv
module rstgen_pin_filter #(
  parameter int unsigned SAMPLES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic pin_n,
  output logic pin_asrt
);

  generate
    if (SAMPLES <= 1) begin : g_single
      logic smp_q;
      always_ff @(posedge clk) begin
        if (clr) smp_q <= 1'b1;
        else     smp_q <= pin_n;
      end
      assign pin_asrt = ~smp_q;
    end else begin : g_multi
      logic [SAMPLES-1:0] smp_q;
      always_ff @(posedge clk) begin
        if (clr) smp_q <= '1;
        else     smp_q <= {smp_q[SAMPLES-2:0], pin_n};
      end
      assign pin_asrt = ~|smp_q;
    end
  endgenerate

endmodule

// File: rtl/rstgen_stretch.sv
module rstgen_stretch #(
  parameter int unsigned MIN_PULSE = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic req,
  output logic active
);

  localparam int unsigned CW = (MIN_PULSE < 2) ? 1 : $clog2(MIN_PULSE + 1);
  localparam logic [CW-1:0] RELOAD = (MIN_PULSE < 2) ? '0 : CW'(MIN_PULSE - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr)                 cnt_q <= '0;
    else if (req)            cnt_q <= RELOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign active = req | (cnt_q != '0);

endmodule

// File: rtl/rstgen_pwr_seq.sv
module rstgen_pwr_seq
  import rstgen_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 8,
  parameter int unsigned TIME_SHIFT = 0,
  parameter int unsigned INIT_US    = INIT_US_DEF
) (
  input  logic       clk,
  input  logic       por_ok,
  input  logic       bod_en,
  input  logic       bod_ok,
  input  logic       xtal_sel,
  input  logic [1:0] sut_code,
  input  logic       pin_hold,
  output logic       hold_d,
  output logic       running
);

  localparam int unsigned INIT_T = us_to_ticks(INIT_US, CLK_PER_US, TIME_SHIFT);
  localparam int unsigned SUT_MAX_T = us_to_ticks(16384, CLK_PER_US, TIME_SHIFT);
  localparam int unsigned MAX_T = (INIT_T > SUT_MAX_T) ? INIT_T : SUT_MAX_T;
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_T - 1);

  pwr_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] sut_last [8];
  logic [CNT_W-1:0] sut_sel;
  logic             brown;

  genvar g;
  generate
    for (g = 0; g < 8; g++) begin : g_sut
      assign sut_last[g] =
        CNT_W'(us_to_ticks(sut_us(1'(g / 4), 2'(g % 4)), CLK_PER_US, TIME_SHIFT) - 1);
    end
  endgenerate

  assign sut_sel = sut_last[{xtal_sel, sut_code}];
  assign brown   = bod_en & ~bod_ok;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      PS_OFF: begin
        state_d = PS_INIT;
        cnt_d   = '0;
      end
      PS_INIT: begin
        if (cnt_q == INIT_LAST) begin
          cnt_d   = '0;
          state_d = brown ? PS_BODWAIT : PS_SUT;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PS_BODWAIT: begin
        cnt_d = '0;
        if (!brown) state_d = PS_SUT;
      end
      PS_SUT: begin
        if (brown) begin
          state_d = PS_BODWAIT;
          cnt_d   = '0;
        end else if (cnt_q == sut_sel) begin
          cnt_d   = '0;
          state_d = pin_hold ? PS_HOLD : PS_RUN;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PS_HOLD: begin
        if (brown)          state_d = PS_BODWAIT;
        else if (!pin_hold) state_d = PS_RUN;
      end
      PS_RUN: begin
        if (brown) state_d = PS_BODWAIT;
      end
      default: begin
        state_d = PS_OFF;
        cnt_d   = '0;
      end
    endcase
    if (!por_ok) begin
      state_d = PS_OFF;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk) begin
    state_q <= state_d;
    cnt_q   <= cnt_d;
  end

  assign hold_d  = (state_d != PS_RUN);
  assign running = (state_q == PS_RUN);

endmodule

// File: rtl/rstgen_core.sv
module rstgen_core
  import rstgen_pkg::*;
#(
  parameter int unsigned CLK_PER_US  = 8,
  parameter int unsigned TIME_SHIFT  = 0,
  parameter int unsigned INIT_US     = INIT_US_DEF,
  parameter int unsigned PIN_SAMPLES = 2,
  parameter int unsigned MIN_PULSE   = 2
) (
  input  logic       clk,
  input  logic       por_ok,
  input  logic       bod_ok,
  input  logic       bod_en,
  input  logic       pin_rst_en,
  input  logic       rst_pin_n,
  input  logic       wdt_req,
  input  logic       sw_req,
  input  logic       xtal_sel,
  input  logic [1:0] sut_code,
  input  logic       pof_clr,
  output logic       rst_out,
  output logic       pof_out
);

  logic cold;
  logic pin_asrt;
  logic hold_d;
  logic running;
  logic run_req;
  logic run_active;
  logic rst_q;
  logic pof_q;

  assign cold = ~por_ok;

  rstgen_pin_filter #(
    .SAMPLES (PIN_SAMPLES)
  ) u_pin (
    .clk      (clk),
    .clr      (cold),
    .pin_n    (rst_pin_n),
    .pin_asrt (pin_asrt)
  );

  rstgen_pwr_seq #(
    .CLK_PER_US (CLK_PER_US),
    .TIME_SHIFT (TIME_SHIFT),
    .INIT_US    (INIT_US)
  ) u_pwr (
    .clk      (clk),
    .por_ok   (por_ok),
    .bod_en   (bod_en),
    .bod_ok   (bod_ok),
    .xtal_sel (xtal_sel),
    .sut_code (sut_code),
    .pin_hold (pin_asrt),
    .hold_d   (hold_d),
    .running  (running)
  );

  // run-time requests: the pin only counts once running and when its fuse is set
  assign run_req = wdt_req | sw_req | (pin_rst_en & pin_asrt & running);

  rstgen_stretch #(
    .MIN_PULSE (MIN_PULSE)
  ) u_str (
    .clk    (clk),
    .clr    (cold),
    .req    (run_req),
    .active (run_active)
  );

  always_ff @(posedge clk) begin
    rst_q <= hold_d | run_active;
  end

  always_ff @(posedge clk) begin
    if (cold)         pof_q <= 1'b1;
    else if (pof_clr) pof_q <= 1'b0;
  end

  assign rst_out = rst_q;
  assign pof_out = pof_q;

endmodule

// File: rtl/rstgen_core_chk.sv
module rstgen_core_chk (
  input logic clk,
  input logic por_ok,
  input logic bod_ok,
  input logic bod_en,
  input logic wdt_req,
  input logic sw_req,
  input logic pof_clr,
  input logic rst_out,
  input logic pof_out
);

  logic [1:0] age = 2'd0;
  logic       armed;

  always_ff @(posedge clk) begin
    if (age != 2'd3) age <= age + 2'd1;
  end

  assign armed = (age == 2'd3);

  AST_POR_LOW_RST: assert property (@(posedge clk) disable iff (!armed)
    $past(!por_ok) |-> rst_out); // R2

  AST_POR_LOW_FLAG: assert property (@(posedge clk) disable iff (!armed)
    $past(!por_ok) |-> pof_out); // R2

  AST_BROWN_RST: assert property (@(posedge clk) disable iff (!armed)
    $past(bod_en && !bod_ok) |-> rst_out); // R6

  AST_STROBE_NOW: assert property (@(posedge clk) disable iff (!armed)
    $past(wdt_req || sw_req) |-> rst_out); // R10

  AST_STROBE_MIN: assert property (@(posedge clk) disable iff (!armed)
    $past(wdt_req || sw_req, 2) |-> rst_out); // R10

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!armed)
    $past(por_ok && pof_clr) |-> !pof_out); // R11

  AST_FLAG_SET_SRC: assert property (@(posedge clk) disable iff (!armed)
    $rose(pof_out) |-> $past(!por_ok)); // R11

  AST_RELEASE_SUPPLY: assert property (@(posedge clk) disable iff (!armed)
    $fell(rst_out) |-> $past(por_ok)); // R3

endmodule

bind rstgen_core rstgen_core_chk u_chk (
  .clk     (clk),
  .por_ok  (por_ok),
  .bod_ok  (bod_ok),
  .bod_en  (bod_en),
  .wdt_req (wdt_req),
  .sw_req  (sw_req),
  .pof_clr (pof_clr),
  .rst_out (rst_out),
  .pof_out (pof_out)
);

// File: tb/rstgen_core_tb.sv
module rstgen_core_tb;

  localparam int INIT_T = 23;   // 92 us at 1 tick/us, shifted right by 2

  logic       clk = 1'b0;
  logic       por_ok = 1'b0;
  logic       bod_ok = 1'b0;
  logic       bod_en = 1'b0;
  logic       pin_rst_en = 1'b0;
  logic       rst_pin_n = 1'b1;
  logic       wdt_req = 1'b0;
  logic       sw_req = 1'b0;
  logic       xtal_sel = 1'b0;
  logic [1:0] sut_code = 2'd0;
  logic       pof_clr = 1'b0;
  logic       rst_out;
  logic       pof_out;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  int    exp_q[$];
  string tag_q[$];
  int    run_len = 0;

  always #4 clk = ~clk;

  rstgen_core #(
    .CLK_PER_US (1),
    .TIME_SHIFT (2)
  ) u_dut (
    .clk        (clk),
    .por_ok     (por_ok),
    .bod_ok     (bod_ok),
    .bod_en     (bod_en),
    .pin_rst_en (pin_rst_en),
    .rst_pin_n  (rst_pin_n),
    .wdt_req    (wdt_req),
    .sw_req     (sw_req),
    .xtal_sel   (xtal_sel),
    .sut_code   (sut_code),
    .pof_clr    (pof_clr),
    .rst_out    (rst_out),
    .pof_out    (pof_out)
  );

  function automatic int sut_ticks(input bit x, input int c);
    int us;
    if (x) us = (c == 0) ? 1024 : (c == 1) ? 2048 : (c == 2) ? 4096 : 16384;
    else   us = (c == 0) ? 16   : (c == 1) ? 512  : (c == 2) ? 1024 : 4096;
    return us >> 2;
  endfunction

  task automatic expect_pulse(input string tag, input int len);
    exp_q.push_back(len);
    tag_q.push_back(tag);
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: measure each reset pulse and compare against the scoreboard
  always @(negedge clk) begin
    if (rst_out === 1'b1) begin
      run_len++;
    end else if (rst_out === 1'b0 && run_len > 0) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1: unexpected reset pulse of %0d cycles, expected none", run_len);
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e != run_len) begin
          fails++;
          $display("FAIL %s: pulse length %0d expected %0d", t, run_len, e);
        end
      end
      run_len = 0;
    end
  end

  // power cycle: supply low for l edges, then high until release
  task automatic power_cycle(input string tag, input int l, input bit x, input int c);
    xtal_sel = x;
    sut_code = 2'(c);
    expect_pulse(tag, l + INIT_T + sut_ticks(x, c));
    por_ok = 1'b0;
    tick(1);
    check_bit("R2 reset on low supply", rst_out, 1'b1);
    check_bit("R2 flag on low supply", pof_out, 1'b1);
    tick(l - 1);
    por_ok = 1'b1;
    tick(INIT_T + sut_ticks(x, c) + 2);
    check_bit({tag, " released"}, rst_out, 1'b0);
  endtask

  task automatic clear_flag();
    pof_clr = 1'b1;
    tick(1);
    pof_clr = 1'b0;
    check_bit("R11 flag cleared", pof_out, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    // reset state after first edge with supply low
    check_bit("R2 reset state rst", rst_out, 1'b1);
    check_bit("R2 reset state flag", pof_out, 1'b1);
    expect_pulse("R3 first power-up", 4 + INIT_T + sut_ticks(0, 0));
    tick(3);
    por_ok = 1'b1;
    tick(INIT_T + sut_ticks(0, 0) + 2);
    check_bit("R3 released", rst_out, 1'b0);
    clear_flag();

    // R4: every clock source / code pairing
    for (int x = 0; x < 2; x++) begin
      for (int c = 0; c < 4; c++) begin
        power_cycle("R4 start-up table", 2, 1'(x), c);
        check_bit("R2 flag after cold start", pof_out, 1'b1);
      end
    end
    xtal_sel = 1'b0;
    sut_code = 2'd0;
    clear_flag();

    // R10 watchdog strobe one cycle -> 2 cycles
    expect_pulse("R1/R10 watchdog strobe", 2);
    wdt_req = 1'b1; tick(1); wdt_req = 1'b0; tick(5);
    // R10 software request held 3 cycles -> 4 cycles
    expect_pulse("R10 software request", 4);
    sw_req = 1'b1; tick(3); sw_req = 1'b0; tick(6);
    check_bit("R11 flag untouched by strobes", pof_out, 1'b0);

    // R7 pin with fuse enabled
    pin_rst_en = 1'b1;
    rst_pin_n = 1'b0; tick(1); rst_pin_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      check_bit("R7 single low sample ignored", rst_out, 1'b0);
      tick(1);
    end
    expect_pulse("R7 pin low 2", 2);
    rst_pin_n = 1'b0; tick(2); rst_pin_n = 1'b1; tick(6);
    expect_pulse("R7 pin low 5", 5);
    rst_pin_n = 1'b0; tick(5); rst_pin_n = 1'b1; tick(8);

    // R8 pin with fuse disabled
    pin_rst_en = 1'b0;
    rst_pin_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      check_bit("R8 pin ignored", rst_out, 1'b0);
    end
    rst_pin_n = 1'b1;
    tick(3);

    // R6 brown-out while running
    bod_en = 1'b1;
    bod_ok = 1'b1;
    tick(2);
    expect_pulse("R6 brown-out", 5 + sut_ticks(0, 0));
    bod_ok = 1'b0; tick(5); bod_ok = 1'b1; tick(sut_ticks(0, 0) + 3);
    check_bit("R6 flag untouched by brown-out", pof_out, 1'b0);
    bod_en = 1'b0;
    bod_ok = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick(1);
      check_bit("R6 monitor disabled", rst_out, 1'b0);
    end
    bod_ok = 1'b1;

    // R5 gated power-up: undervoltage clears late
    bod_en = 1'b1;
    expect_pulse("R5 late good level", 3 + 40 + sut_ticks(0, 0));
    por_ok = 1'b0; bod_ok = 1'b0;
    tick(3);
    por_ok = 1'b1;
    tick(40);
    bod_ok = 1'b1;
    tick(sut_ticks(0, 0) + 3);
    // R5 gated power-up: undervoltage clears before init ends
    expect_pulse("R5 early good level", 3 + INIT_T + sut_ticks(0, 0));
    por_ok = 1'b0; bod_ok = 1'b0;
    tick(3);
    por_ok = 1'b1;
    tick(5);
    bod_ok = 1'b1;
    tick(INIT_T + sut_ticks(0, 0));
    bod_en = 1'b0;

    // R9 pin held low through power-up with fuse disabled
    pin_rst_en = 1'b0;
    expect_pulse("R9 pin extends power-up", 3 + 40 + 1);
    por_ok = 1'b0; rst_pin_n = 1'b0;
    tick(3);
    por_ok = 1'b1;
    tick(40);
    check_bit("R9 still held", rst_out, 1'b1);
    rst_pin_n = 1'b1;
    tick(1);
    check_bit("R9 held one more edge", rst_out, 1'b1);
    tick(1);
    check_bit("R9 released", rst_out, 1'b0);
    tick(4);

    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1: %0d predicted pulses missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R1: watchdog expired, got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule